// File: doc/BRIEF.md
# Banked Expansion RAM DMA Controller

This block is a register-programmed DMA engine. It moves bytes between a 16-bit host memory space and a banked expansion RAM. The host programs a host start address, an expansion start address and bank, a byte count and a step control. A write to the command register then chooses one of four operations. Stash copies host bytes into expansion RAM. Fetch copies the other way. Swap exchanges the two regions. Verify compares them and stops at the first difference.

A transfer can begin in two ways. It can start in the clock after the command write. It can also be armed and held until the host bus writes to a fixed trigger address. The block watches the host write bus to detect that write. Each address register keeps two copies: the value the host last wrote, and a working value that the transfer advances. When autoload is on, the written values are copied back into the working registers at the end of a transfer. The block reports end of block, verify fault and a maskable interrupt through a status register. Reading the status register clears these flags.

Both memory ports are simple and have no wait states. Read data must be valid in the same cycle as the request, and writes take effect at the clock edge. The bench supplies both memories as behavioural models.

Top module: `xramDma`

## Requirements
- R1: After reset, the outputs and registers hold these values: busy=0, irq=0, status (offset 0) reads 0x00, command (offset 1) reads 0x10, and every address, bank, length, interrupt-control and step register reads 0.
- R2: Command bits [1:0] select the operation. Code 0 copies host to expansion and code 1 copies expansion to host. Both copy one byte per clock, so busy stays high for exactly as many cycles as the programmed length.
- R3: Code 2 swaps the two regions. Each byte pair takes two clocks: one reads both sides and the next writes both sides. Busy stays high for twice the length.
- R4: Code 3 compares the two regions without writing either. At the first unequal pair, status bit 5 is set and the transfer ends with the addresses left on that pair.
- R5: A command write with bit 7 set and bit 4 set starts a transfer in the next clock. With bit 7 set and bit 4 clear, the block arms and stays idle. While armed, only a host-bus write to address 0xFF00 starts the transfer, and a write to any other address does not. When a transfer starts, command bit 7 reads 0 and bit 4 reads 1.
- R6: Step control bit 0 holds the host address fixed, and bit 1 holds the expansion address fixed. Otherwise each address steps by one after every byte except the last. The 16-bit expansion address carries into the bank. The bank register keeps only log2(BANKS) bits, so with the defaults 0xFF reads back as 0x07.
- R7: When command bit 5 (autoload) is set, the host address, expansion address, bank and length return to their last written values at the end of a transfer. When it is clear, these registers keep the final byte's address and the remaining length. That remaining length is 1 after a full transfer.
- R8: Status bit 6 is set after the transfer if the last byte processed had remaining length 1, and is clear otherwise.
- R9: When interrupt-control bit 0 (offset 9) is set, the end of a transfer sets status bit 7 and raises irq. Reading the status register clears bits 7, 6 and 5 and drops irq. When interrupt-control bit 0 is clear, irq and status bit 7 stay 0.
- R10: While busy, register writes are ignored. This includes writes to the address registers and to the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; used only for read-clear of status |
| regAddr | input | 4 | Register offset (0 status, 1 command, 2/3 host lo/hi, 4/5 expansion lo/hi, 6 bank, 7/8 length lo/hi, 9 interrupt control, 10 step control) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| snoopWr | input | 1 | Host bus write seen this cycle |
| snoopAddr | input | 16 | Address of the snooped host write |
| hostReq | output | 1 | Host memory access this cycle |
| hostWe | output | 1 | Host memory write |
| hostAddr | output | 16 | Host memory address |
| hostWrData | output | 8 | Host memory write data |
| hostRdData | input | 8 | Host memory read data, same cycle |
| xramReq | output | 1 | Expansion RAM access this cycle |
| xramWe | output | 1 | Expansion RAM write |
| xramAddr | output | 16+log2(BANKS) | Bank and address of expansion RAM |
| xramWrData | output | 8 | Expansion RAM write data |
| xramRdData | input | 8 | Expansion RAM read data, same cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | End-of-block interrupt |

## Verification
The assertions assume that read data from both memories is valid in the cycle of the request. They also assume that the only way the controller can leave a busy cycle is the last-byte or compare-fault condition. The stimulus keeps the first assumption because both memory models answer combinationally. The bench waits for busy to fall before it reads status or programs the next transfer. Stimulus addresses are random across the full 16-bit space, but the memory models decode only their low address bits. The bench model uses the same decode, so aliased bytes stay consistent between the model and the design.

// File: rtl/xramDmaPkg.sv
package xramDmaPkg;

  typedef enum logic [1:0] {
    OP_STASH  = 2'd0,
    OP_FETCH  = 2'd1,
    OP_SWAP   = 2'd2,
    OP_VERIFY = 2'd3
  } dmaOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   active;   // a transfer cycle is in progress
    logic   phaseWr;  // swap write half
    logic   capture;  // swap read half: latch both bytes
    logic   step;     // advance addresses, decrement length
    logic   reload;   // autoload working registers
    dmaOp_e op;
  } dmaStrobe_t;

  localparam logic [3:0] REG_STATUS = 4'd0;
  localparam logic [3:0] REG_CMD    = 4'd1;
  localparam logic [3:0] REG_HLO    = 4'd2;
  localparam logic [3:0] REG_HHI    = 4'd3;
  localparam logic [3:0] REG_XLO    = 4'd4;
  localparam logic [3:0] REG_XHI    = 4'd5;
  localparam logic [3:0] REG_BANK   = 4'd6;
  localparam logic [3:0] REG_LLO    = 4'd7;
  localparam logic [3:0] REG_LHI    = 4'd8;
  localparam logic [3:0] REG_IRQ    = 4'd9;
  localparam logic [3:0] REG_STEP   = 4'd10;

endpackage

// File: rtl/xramDmaCtrl.sv
module xramDmaCtrl
  import xramDmaPkg::*;
#(
  parameter logic [15:0] TRIG_ADDR = 16'hFF00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic        snoopWr,
  input  logic [15:0] snoopAddr,
  input  logic        lenIsOne,
  input  logic        mismatch,
  output dmaStrobe_t  strobe,
  output logic        busy,
  output logic        irq,
  output logic [7:0]  rdData
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_XFER, S_SWAPWR} state_e;

  state_e state;
  logic [7:0] cr;
  logic irqEn, stIrq, stEob, stFault;
  dmaOp_e op;
  logic regWr, crWr, trigHit, byteDone, verifyFail, finish, statusRd;

  assign op         = dmaOp_e'(cr[1:0]);
  assign busy       = (state == S_XFER) || (state == S_SWAPWR);
  assign regWr      = regWrEn && !busy;
  assign crWr       = regWr && (regAddr == REG_CMD);
  assign trigHit    = (state == S_ARMED) && snoopWr && (snoopAddr == TRIG_ADDR);
  assign byteDone   = busy && ((op != OP_SWAP) || (state == S_SWAPWR));
  assign verifyFail = (op == OP_VERIFY) && mismatch;
  assign finish     = byteDone && (lenIsOne || verifyFail);
  assign statusRd   = regRdEn && (regAddr == REG_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cr      <= 8'h10;
      irqEn   <= 1'b0;
      stIrq   <= 1'b0;
      stEob   <= 1'b0;
      stFault <= 1'b0;
    end else begin
      if (statusRd) begin
        stIrq   <= 1'b0;
        stEob   <= 1'b0;
        stFault <= 1'b0;
      end
      if (regWr && (regAddr == REG_IRQ)) irqEn <= regWrData[0];

      case (state)
        S_IDLE, S_ARMED: begin
          if (crWr) begin
            if (regWrData[7] && regWrData[4]) begin
              cr    <= {1'b0, regWrData[6:5], 1'b1, regWrData[3:0]};
              state <= S_XFER;
            end else begin
              cr    <= regWrData;
              state <= regWrData[7] ? S_ARMED : S_IDLE;
            end
          end else if (trigHit) begin
            cr[7] <= 1'b0;
            cr[4] <= 1'b1;
            state <= S_XFER;
          end
        end
        S_XFER:   if (op == OP_SWAP) state <= S_SWAPWR;
        default:  state <= S_XFER;
      endcase

      // end-of-block status is updated before the finish decision
      if (byteDone) begin
        stEob <= lenIsOne;
        if (verifyFail) stFault <= 1'b1;
        if (finish) begin
          state <= S_IDLE;
          if (irqEn) stIrq <= 1'b1;
        end
      end
    end
  end

  assign strobe.active  = busy;
  assign strobe.phaseWr = (state == S_SWAPWR);
  assign strobe.capture = (state == S_XFER) && (op == OP_SWAP);
  assign strobe.step    = byteDone && !finish;
  assign strobe.reload  = finish && cr[5];
  assign strobe.op      = op;

  assign irq = stIrq;

  always_comb begin
    case (regAddr)
      REG_STATUS: rdData = {stIrq, stEob, stFault, 5'b0};
      REG_CMD:    rdData = cr;
      REG_IRQ:    rdData = {7'b0, irqEn};
      default:    rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/xramDmaPath.sv
module xramDmaPath
  import xramDmaPkg::*;
#(
  parameter int BANKS  = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int XW     = 16 + BANK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busy,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  dmaStrobe_t       strobe,
  output logic             hostReq,
  output logic             hostWe,
  output logic [15:0]      hostAddr,
  output logic [7:0]       hostWrData,
  input  logic [7:0]       hostRdData,
  output logic             xramReq,
  output logic             xramWe,
  output logic [XW-1:0]    xramAddr,
  output logic [7:0]       xramWrData,
  input  logic [7:0]       xramRdData,
  output logic             lenIsOne,
  output logic             mismatch,
  output logic [7:0]       rdData
);

  logic [15:0]       hostCur, hostLat, xCur, xLat, lenCur, lenLat;
  logic [BANK_W-1:0] bankCur, bankLat;
  logic [1:0]        stepCtl;
  logic [7:0]        hostBuf, xBuf;
  logic [XW-1:0]     xNext;
  logic              regWr, isSwap;

  assign regWr  = regWrEn && !busy;
  assign xNext  = {bankCur, xCur} + XW'(1);
  assign isSwap = (strobe.op == OP_SWAP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostCur <= '0; hostLat <= '0;
      xCur    <= '0; xLat    <= '0;
      bankCur <= '0; bankLat <= '0;
      lenCur  <= '0; lenLat  <= '0;
      stepCtl <= '0;
      hostBuf <= '0; xBuf    <= '0;
    end else if (regWr) begin
      case (regAddr)
        REG_HLO:  begin hostCur[7:0]  <= regWrData; hostLat[7:0]  <= regWrData; end
        REG_HHI:  begin hostCur[15:8] <= regWrData; hostLat[15:8] <= regWrData; end
        REG_XLO:  begin xCur[7:0]     <= regWrData; xLat[7:0]     <= regWrData; end
        REG_XHI:  begin xCur[15:8]    <= regWrData; xLat[15:8]    <= regWrData; end
        REG_BANK: begin bankCur <= regWrData[BANK_W-1:0]; bankLat <= regWrData[BANK_W-1:0]; end
        REG_LLO:  begin lenCur[7:0]   <= regWrData; lenLat[7:0]   <= regWrData; end
        REG_LHI:  begin lenCur[15:8]  <= regWrData; lenLat[15:8]  <= regWrData; end
        REG_STEP: stepCtl <= regWrData[1:0];
        default: ;
      endcase
    end else begin
      if (strobe.capture) begin
        hostBuf <= hostRdData;
        xBuf    <= xramRdData;
      end
      if (strobe.reload) begin
        hostCur <= hostLat;
        xCur    <= xLat;
        bankCur <= bankLat;
        lenCur  <= lenLat;
      end else if (strobe.step) begin
        if (!stepCtl[0]) hostCur <= hostCur + 16'd1;
        if (!stepCtl[1]) {bankCur, xCur} <= xNext;
        lenCur <= lenCur - 16'd1;
      end
    end
  end

  assign lenIsOne = (lenCur == 16'd1);
  assign mismatch = (hostRdData != xramRdData);

  assign hostReq    = strobe.active;
  assign hostWe     = strobe.active && ((strobe.op == OP_FETCH) || (isSwap && strobe.phaseWr));
  assign hostAddr   = hostCur;
  assign hostWrData = isSwap ? xBuf : xramRdData;

  assign xramReq    = strobe.active;
  assign xramWe     = strobe.active && ((strobe.op == OP_STASH) || (isSwap && strobe.phaseWr));
  assign xramAddr   = {bankCur, xCur};
  assign xramWrData = isSwap ? hostBuf : hostRdData;

  always_comb begin
    case (regAddr)
      REG_HLO:  rdData = hostCur[7:0];
      REG_HHI:  rdData = hostCur[15:8];
      REG_XLO:  rdData = xCur[7:0];
      REG_XHI:  rdData = xCur[15:8];
      REG_BANK: rdData = 8'(bankCur);
      REG_LLO:  rdData = lenCur[7:0];
      REG_LHI:  rdData = lenCur[15:8];
      REG_STEP: rdData = {6'b0, stepCtl};
      default:  rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/xramDma.sv
module xramDma
  import xramDmaPkg::*;
#(
  parameter int          BANKS     = 8,
  parameter logic [15:0] TRIG_ADDR = 16'hFF00,
  localparam int         XW        = 16 + $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [3:0]    regAddr,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  input  logic          snoopWr,
  input  logic [15:0]   snoopAddr,
  output logic          hostReq,
  output logic          hostWe,
  output logic [15:0]   hostAddr,
  output logic [7:0]    hostWrData,
  input  logic [7:0]    hostRdData,
  output logic          xramReq,
  output logic          xramWe,
  output logic [XW-1:0] xramAddr,
  output logic [7:0]    xramWrData,
  input  logic [7:0]    xramRdData,
  output logic          busy,
  output logic          irq
);

  dmaStrobe_t strobe;
  logic lenIsOne, mismatch;
  logic [7:0] ctrlRd, pathRd;

  xramDmaCtrl #(.TRIG_ADDR(TRIG_ADDR)) ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .snoopWr(snoopWr), .snoopAddr(snoopAddr),
    .lenIsOne(lenIsOne), .mismatch(mismatch),
    .strobe(strobe), .busy(busy), .irq(irq), .rdData(ctrlRd)
  );

  xramDmaPath #(.BANKS(BANKS)) path (
    .clk(clk), .rstN(rstN), .busy(busy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .xramReq(xramReq), .xramWe(xramWe), .xramAddr(xramAddr),
    .xramWrData(xramWrData), .xramRdData(xramRdData),
    .lenIsOne(lenIsOne), .mismatch(mismatch), .rdData(pathRd)
  );

  assign regRdData = ctrlRd | pathRd;

endmodule

// File: rtl/xramDmaChk.sv
module xramDmaChk
  import xramDmaPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       irq,
  input logic       hostReq,
  input logic       xramReq,
  input logic       regRdEn,
  input logic [3:0] regAddr,
  input dmaStrobe_t strobe,
  input logic       mismatch
);

  // R2: no memory traffic outside a transfer
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!hostReq && !xramReq));

  // R3: a swap write half always follows a read half
  a_r3_swap_order: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseWr |-> $past(strobe.capture));

  // R4: a compare fault ends the transfer
  a_r4_fault_ends: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && strobe.op == OP_VERIFY && mismatch) |=> !busy);

  // R9: reading status while idle leaves irq low afterwards
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == REG_STATUS && !busy) |=> !irq);

  // R9: irq only rises right after a transfer cycle
  a_r9_irq_after_xfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busy));

endmodule

bind xramDma xramDmaChk chk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq),
  .hostReq(hostReq), .xramReq(xramReq),
  .regRdEn(regRdEn), .regAddr(regAddr),
  .strobe(strobe), .mismatch(mismatch)
);

// File: tb/xramDma_test.sv
`timescale 1ns/1ps
module xramDma_test;

  localparam int BANKS = 8;
  localparam int XW = 16 + $clog2(BANKS);

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic snoopWr = 0;
  logic [15:0] snoopAddr = 0;
  logic hostReq, hostWe, xramReq, xramWe, busy, irq;
  logic [15:0] hostAddr;
  logic [XW-1:0] xramAddr;
  logic [7:0] hostWrData, xramWrData, hostRdData, xramRdData;

  logic [7:0] hostMem [256];
  logic [7:0] xramMem [512];
  logic [7:0] eHost [256];
  logic [7:0] eXram [512];

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  xramDma #(.BANKS(BANKS)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .snoopWr(snoopWr), .snoopAddr(snoopAddr),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .xramReq(xramReq), .xramWe(xramWe), .xramAddr(xramAddr),
    .xramWrData(xramWrData), .xramRdData(xramRdData),
    .busy(busy), .irq(irq)
  );

  // behavioural memories, low address bits decoded
  function automatic int xIdx(input logic [XW-1:0] a);
    return {a[16], a[7:0]};
  endfunction

  assign hostRdData = hostMem[hostAddr[7:0]];
  assign xramRdData = xramMem[xIdx(xramAddr)];

  always @(posedge clk) begin
    if (hostReq && hostWe) hostMem[hostAddr[7:0]] <= hostWrData;
    if (xramReq && xramWe) xramMem[xIdx(xramAddr)] <= xramWrData;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1; #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic snoop(input logic [15:0] a);
    @(negedge clk); snoopAddr = a; snoopWr = 1;
    @(negedge clk); snoopWr = 0;
  endtask

  task automatic fillMem();
    for (int i = 0; i < 256; i++) hostMem[i] = 8'($urandom);
    for (int i = 0; i < 512; i++) xramMem[i] = 8'($urandom);
  endtask

  // op: 0 stash, 1 fetch, 2 swap, 3 verify
  task automatic runXfer(input string tag, input int op, input logic [15:0] hA,
                         input logic [15:0] xA, input logic [7:0] bank, input int len,
                         input bit hFix, input bit xFix, input bit auto, input bit irqOn,
                         input bit useTrig, input bit poke);
    logic [7:0] cmd, b0, b1;
    logic [XW-1:0] xStart, xp;
    logic [15:0] hp;
    int k, cnt, diff;
    bit fault;
    logic [7:0] t;
    xStart = {bank[XW-17:0], xA};
    for (int i = 0; i < 256; i++) eHost[i] = hostMem[i];
    for (int i = 0; i < 512; i++) eXram[i] = xramMem[i];
    // bench model
    k = len - 1; fault = 0;
    for (int i = 0; i < len; i++) begin
      hp = hA + (hFix ? 16'd0 : 16'(i));
      xp = xStart + (xFix ? XW'(0) : XW'(i));
      case (op)
        0: eXram[xIdx(xp)] = eHost[hp[7:0]];
        1: eHost[hp[7:0]] = eXram[xIdx(xp)];
        2: begin t = eHost[hp[7:0]]; eHost[hp[7:0]] = eXram[xIdx(xp)]; eXram[xIdx(xp)] = t; end
        default: if (eHost[hp[7:0]] != eXram[xIdx(xp)]) begin fault = 1; k = i; break; end
      endcase
    end
    wr(4'd2, hA[7:0]); wr(4'd3, hA[15:8]);
    wr(4'd4, xA[7:0]); wr(4'd5, xA[15:8]);
    wr(4'd6, bank);
    wr(4'd7, 8'(len)); wr(4'd8, 8'(len >> 8));
    wr(4'd9, {7'b0, irqOn});
    wr(4'd10, {6'b0, xFix, hFix});
    cmd = {1'b1, 1'b0, auto, !useTrig, 2'b00, 2'(op)};
    wr(4'd1, cmd);
    if (useTrig) begin
      check({tag, " R5 armed idle"}, busy, 0);
      snoop(16'hFF01);
      check({tag, " R5 wrong trigger addr"}, busy, 0);
      snoop(16'hFF00);
    end
    check({tag, " R5 started"}, busy, 1);
    if (poke) begin
      wr(4'd2, 8'h55);
      wr(4'd1, 8'h03);
    end
    cnt = 0;
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    if (!poke) check({tag, op == 2 ? " R3 swap cycles" : " R2 cycles"}, cnt,
                     fault ? k + 1 : (op == 2 ? 2 * len : len));
    diff = 0;
    for (int i = 0; i < 256; i++) if (hostMem[i] !== eHost[i]) diff++;
    check({tag, " R2 host memory"}, diff, 0);
    diff = 0;
    for (int i = 0; i < 512; i++) if (xramMem[i] !== eXram[i]) diff++;
    check({tag, " R2 expansion memory"}, diff, 0);
    hp = auto ? hA : hA + (hFix ? 16'd0 : 16'(k));
    xp = auto ? xStart : xStart + (xFix ? XW'(0) : XW'(k));
    rd(4'd2, b0); rd(4'd3, b1);
    check({tag, " R6 R7 R10 host addr"}, {b1, b0}, hp);
    rd(4'd4, b0); rd(4'd5, b1);
    check({tag, " R6 R7 expansion addr"}, {b1, b0}, xp[15:0]);
    rd(4'd6, b0);
    check({tag, " R6 R7 bank"}, b0, xp[XW-1:16]);
    rd(4'd7, b0); rd(4'd8, b1);
    check({tag, " R7 length"}, {b1, b0}, auto ? len : len - k);
    rd(4'd1, b0);
    check({tag, " R5 R10 command"}, b0, (cmd & 8'h7F) | 8'h10);
    check({tag, " R9 irq output"}, irq, irqOn);
    rd(4'd0, b0);
    check({tag, " R4 R8 R9 status"}, b0, {irqOn, (len - k) == 1, fault, 5'b0});
    rd(4'd0, b0);
    check({tag, " R9 status cleared"}, b0, 0);
    check({tag, " R9 irq cleared"}, irq, 0);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    fillMem();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 irq", irq, 0);
    rd(4'd0, d); check("R1 status", d, 0);
    rd(4'd1, d); check("R1 command", d, 8'h10);
    for (int a = 2; a <= 10; a++) begin
      rd(4'(a), d); check("R1 register", d, 0);
    end
    // R6 bank mask
    wr(4'd6, 8'hFF); rd(4'd6, d); check("R6 bank mask", d, 8'h07);

    // directed cases
    runXfer("stash", 0, 16'h0010, 16'h0020, 8'd0, 8, 0, 0, 0, 1, 0, 0);
    runXfer("fetch", 1, 16'h0040, 16'h1230, 8'd1, 5, 0, 0, 1, 1, 0, 0);
    runXfer("swap", 2, 16'h0080, 16'h0090, 8'd0, 6, 0, 0, 0, 1, 0, 0);
    runXfer("trigger", 0, 16'h00A0, 16'h0005, 8'd1, 4, 0, 0, 0, 1, 1, 0);
    runXfer("carry R6", 0, 16'h00C0, 16'hFFFF, 8'd0, 3, 0, 0, 0, 1, 0, 0);
    runXfer("fixed R6", 1, 16'h00D0, 16'h0070, 8'd0, 4, 1, 0, 0, 0, 0, 0);
    runXfer("noirq R9", 0, 16'h0001, 16'h0002, 8'd0, 1, 0, 1, 1, 0, 0, 0);
    runXfer("busy R10", 0, 16'h0030, 16'h0050, 8'd0, 20, 0, 0, 0, 1, 0, 1);
    // R4 verify with a planted difference at index 2
    for (int i = 0; i < 6; i++) xramMem[8'h60 + i] = hostMem[8'h60 + i];
    xramMem[8'h62] = hostMem[8'h62] ^ 8'h01;
    runXfer("verify fault R4", 3, 16'h0060, 16'h0060, 8'd0, 6, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) xramMem[8'hE0 + i] = hostMem[8'hE0 + i];
    runXfer("verify pass R4", 3, 16'h00E0, 16'h00E0, 8'd0, 4, 0, 0, 1, 1, 0, 0);

    // random cases
    for (int n = 0; n < 20; n++) begin
      runXfer("random", int'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
              8'($urandom), int'($urandom_range(1, 24)), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule